// File: doc/BRIEF.md
# Snooping write-invalidate cache line controller

This block keeps the line states of one private write-back data cache that shares a single memory bus with peer caches and main memory. It serves loads and stores from its own processor. It also watches every transaction that a peer places on the bus. Each line of a small direct-mapped array is held in one of three states: Invalid, Shared (clean, possibly held elsewhere) or Modified (dirty, held only here).

The bus is modelled as single-cycle transactions. The master that holds the grant drives a command, a line address and its id. In the same cycle, the addressed line's data comes back on the data input, from memory or from a peer that intervenes. An external fixed-priority arbiter answers this cache's request line with a grant. A peer miss on a line held dirty here is answered in the same cycle: the cache raises a supply flag that cancels the memory read, and it drives its copy onto the bus. Memory captures that same copy, so both owner and requester end clean after a read.

Top module: `snoop_msi_cache`

## Requirements
- R1: After reset every line is Invalid: any processor request sees cpu_ready low and bus_req high.
- R2: A read miss on a clean or absent line issues command RD (code 0) with the request's line address once granted, stores bus_din as the line in Shared, and the held read then completes with cpu_rdata equal to that data.
- R3: A write miss issues command RFO (code 1), fills the line from bus_din in Modified, and the held write then completes with cpu_ready, storing cpu_wdata.
- R4: A write to a line held Modified completes in the same cycle with bus_req and out_valid low.
- R5: A write to a line held Shared first issues command UPG (code 2), an invalidate without data, then completes with the line Modified.
- R6: A peer RD on a line held Modified raises snp_supply in the same cycle with bus_dout equal to the line, and leaves the line Shared, so that a later write needs the bus again.
- R7: A peer RFO on a line held here leaves it Invalid. snp_supply rises, with the line on bus_dout, only if the line was Modified.
- R8: A peer UPG on a line held here leaves it Invalid.
- R9: A miss whose direct-mapped slot holds a different Modified line first issues command WB (code 3) with the victim's address and data on out_addr and bus_dout, and then issues the fill command.
- R10: A miss whose slot holds a different Shared line drops that line silently and issues the fill command directly.
- R11: bus_req is high exactly when a request is pending that cannot complete from the array. out_valid rises only with bus_gnt and only when no peer snoop occupies that cycle. A processor access is held off while a peer snoop targets its array index.
- R12: Bus transactions that carry this cache's own id (MY_ID) on snp_id cause no state change and no supply.
- R13: cpu_ready is high only for a request whose line is held with matching tag in Modified, or in Shared for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Line address of the access |
| cpu_wdata | input | DATA_W | Line data to write |
| cpu_rdata | output | DATA_W | Line data read |
| cpu_ready | output | 1 | Access completes this cycle |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Grant from the arbiter |
| out_valid | output | 1 | This cache drives a command this cycle |
| out_cmd | output | 2 | RD=0, RFO=1, UPG=2, WB=3 |
| out_addr | output | ADDR_W | Line address of the own command |
| out_id | output | ID_W | This cache's id |
| bus_dout | output | DATA_W | Write-back or intervention data |
| bus_din | input | DATA_W | Line data returned for an own RD/RFO |
| snp_valid | input | 1 | A transaction is on the bus |
| snp_cmd | input | 2 | Command of that transaction |
| snp_addr | input | ADDR_W | Line address of that transaction |
| snp_id | input | ID_W | Id of its master |
| snp_supply | output | 1 | Cancel memory read; this cache supplies data |

## Verification
The assertions assume that the processor holds its address and direction steady while it waits and that the arbiter grants only while bus_req is high. They also assume that, after an own fill or upgrade, a peer that snoops in the next cycle may legitimately keep the access waiting. For that reason the completion property only demands cpu_ready when no snoop is present. The stimulus holds every request until it completes. It also injects peer snoops in grant cycles, on the index of a waiting access, and with the cache's own id, so that each waiting rule is exercised on both sides.

// File: rtl/snoop_msi_cache.sv
module snoop_msi_cache #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 32,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              out_valid,
  output logic [1:0]        out_cmd,
  output logic [ADDR_W-1:0] out_addr,
  output logic [ID_W-1:0]   out_id,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ID_W-1:0]   snp_id,
  output logic              snp_supply
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2;
  localparam logic [1:0] C_RD = 2'd0, C_RFO = 2'd1, C_UPG = 2'd2, C_WB = 2'd3;

  logic [1:0]        st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  logic [IDX_W-1:0] cidx, sidx;
  logic [TAG_W-1:0] ctag, stag;
  logic [1:0] cst, sst;
  logic cmatch, smatch, chit, snp_live, need_wb;

  assign cidx = cpu_addr[IDX_W-1:0];
  assign ctag = cpu_addr[ADDR_W-1:IDX_W];
  assign sidx = snp_addr[IDX_W-1:0];
  assign stag = snp_addr[ADDR_W-1:IDX_W];
  assign cst  = st_q[cidx];
  assign sst  = st_q[sidx];

  assign cmatch   = (cst != ST_I) && (tag_q[cidx] == ctag);
  assign smatch   = (sst != ST_I) && (tag_q[sidx] == stag);
  assign chit     = cmatch && ((cst == ST_M) || !cpu_we);
  assign snp_live = snp_valid && (snp_id != ID_W'(MY_ID));
  assign need_wb  = !cmatch && (cst == ST_M);

  assign snp_supply = snp_live && smatch && (sst == ST_M) &&
                      ((snp_cmd == C_RD) || (snp_cmd == C_RFO));
  assign cpu_ready  = cpu_req && chit && !(snp_live && (sidx == cidx));
  assign cpu_rdata  = dat_q[cidx];
  assign bus_req    = cpu_req && !chit;
  assign out_valid  = bus_req && bus_gnt && !snp_live;
  assign out_cmd    = need_wb ? C_WB : cmatch ? C_UPG : cpu_we ? C_RFO : C_RD;
  assign out_addr   = need_wb ? {tag_q[cidx], cidx} : cpu_addr;
  assign out_id     = ID_W'(MY_ID);
  assign bus_dout   = snp_supply ? dat_q[sidx] : dat_q[cidx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= ST_I;
    end else if (snp_live && smatch) begin
      st_q[sidx] <= (snp_cmd == C_RD) ? ST_S : (snp_cmd == C_WB) ? sst : ST_I;
    end else if (out_valid) begin
      case (out_cmd)
        C_WB:    st_q[cidx] <= ST_I;
        C_RD:    st_q[cidx] <= ST_S;
        default: st_q[cidx] <= ST_M;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (out_valid && ((out_cmd == C_RD) || (out_cmd == C_RFO))) begin
      tag_q[cidx] <= ctag;
      dat_q[cidx] <= bus_din;
    end else if (cpu_ready && cpu_we) begin
      dat_q[cidx] <= cpu_wdata;
    end
  end
endmodule

// File: rtl/snoop_msi_cache_props.sv
module snoop_msi_cache_props #(
  parameter int ADDR_W = 8,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ready,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              out_valid,
  input logic [1:0]        out_cmd,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic [ID_W-1:0]   snp_id,
  input logic              snp_supply
);
  assert_grant_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (bus_gnt && bus_req && !(snp_valid && snp_id != ID_W'(MY_ID))));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req |-> (!bus_req && !cpu_ready));

  assert_dirty_write_local_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && cpu_ready) |-> (!bus_req && !out_valid));

  assert_supply_on_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> (snp_valid && (snp_cmd == 2'd0 || snp_cmd == 2'd1)));

  assert_own_id_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_id == ID_W'(MY_ID)) |-> !snp_supply);

  assert_fill_completes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cmd != 2'd3) |=>
      ((cpu_req && $stable(cpu_addr) && $stable(cpu_we) && !snp_valid) -> cpu_ready));

  assert_upgrade_is_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cmd == 2'd2) |-> cpu_we);
endmodule

bind snoop_msi_cache snoop_msi_cache_props #(.ADDR_W(ADDR_W), .ID_W(ID_W), .MY_ID(MY_ID)) u_props (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_gnt(bus_gnt), .out_valid(out_valid),
  .out_cmd(out_cmd), .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_id(snp_id),
  .snp_supply(snp_supply)
);

// File: tb/snoop_msi_cache_test.sv
module snoop_msi_cache_test;
  localparam int NIDX = 4;
  localparam int RD = 0, RFO = 1, UPG = 2, WB = 3;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0, bus_gnt = 0, snp_valid = 0;
  logic [7:0] cpu_addr = 0, snp_addr = 0, out_addr;
  logic [31:0] cpu_wdata = 0, bus_din = 0, cpu_rdata, bus_dout;
  logic [1:0] snp_cmd = 0, out_cmd, snp_id = 0, out_id;
  logic cpu_ready, bus_req, out_valid, snp_supply;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;
  int mst[int];
  logic [31:0] mdat[int];
  logic [31:0] mem[int];

  always #5 clk = ~clk;

  snoop_msi_cache #(.ADDR_W(8), .IDX_W(2), .DATA_W(32), .ID_W(2), .MY_ID(0)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .out_valid(out_valid), .out_cmd(out_cmd), .out_addr(out_addr),
    .out_id(out_id), .bus_dout(bus_dout), .bus_din(bus_din), .snp_valid(snp_valid),
    .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_id(snp_id), .snp_supply(snp_supply));

  function automatic int stof(int a);
    return mst.exists(a) ? mst[a] : 0;
  endfunction

  function automatic int vict(int a);
    foreach (mst[k]) if (k != a && (k % NIDX) == (a % NIDX) && mst[k] != 0) return k;
    return -1;
  endfunction

  function automatic logic [31:0] memv(int a);
    return mem.exists(a) ? mem[a] : (32'hC0DE_0000 + a);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  task automatic cyc(string tag, bit req, bit we, int addr, logic [31:0] wd, bit gnt,
                     bit sv = 0, int scmd = 0, int saddr = 0, int sid = 1, logic [31:0] dx = 0);
    bit live, hit, e_ready, e_breq, e_ov, e_sup;
    int st, v, e_cmd, e_addr;
    logic [31:0] din;
    din = memv(addr) ^ dx;
    cpu_req = req; cpu_we = we; cpu_addr = 8'(addr); cpu_wdata = wd; bus_gnt = gnt;
    snp_valid = sv; snp_cmd = 2'(scmd); snp_addr = 8'(saddr); snp_id = 2'(sid); bus_din = din;
    live = sv && sid != 0;
    st = stof(addr); v = vict(addr);
    hit = (st == 2) || (st == 1 && !we);
    e_ready = req && hit && !(live && (saddr % NIDX) == (addr % NIDX));
    e_breq = req && !hit;
    e_ov = e_breq && gnt && !live;
    e_cmd = (v >= 0 && stof(v) == 2) ? WB : (st == 1) ? UPG : we ? RFO : RD;
    e_addr = (e_cmd == WB) ? v : addr;
    e_sup = live && (scmd == RD || scmd == RFO) && stof(saddr) == 2;
    #4;
    chk(tag, "cpu_ready", 32'(cpu_ready), 32'(e_ready));
    chk(tag, "bus_req", 32'(bus_req), 32'(e_breq));
    chk(tag, "out_valid", 32'(out_valid), 32'(e_ov));
    chk(tag, "snp_supply", 32'(snp_supply), 32'(e_sup));
    chk(tag, "out_id", 32'(out_id), 32'd0);
    if (e_ready && !we) chk(tag, "cpu_rdata", cpu_rdata, mdat[addr]);
    if (e_ov) begin
      chk(tag, "out_cmd", 32'(out_cmd), 32'(e_cmd));
      chk(tag, "out_addr", 32'(out_addr), 32'(e_addr));
      if (e_cmd == WB) chk(tag, "bus_dout wb", bus_dout, mdat[v]);
    end
    if (e_sup) chk(tag, "bus_dout supply", bus_dout, mdat[saddr]);
    @(posedge clk);
    if (e_ready && we) mdat[addr] = wd;
    if (e_ov) begin
      case (e_cmd)
        WB:  begin mem[v] = mdat[v]; mst[v] = 0; end
        UPG: mst[addr] = 2;
        default: begin
          if (v >= 0) mst[v] = 0;
          mst[addr] = (e_cmd == RD) ? 1 : 2;
          mdat[addr] = din;
        end
      endcase
    end
    if (live && stof(saddr) != 0) begin
      if (e_sup) mem[saddr] = mdat[saddr];
      if (scmd == RD) mst[saddr] = 1;
      else if (scmd != WB) mst[saddr] = 0;
    end
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog got %0d exp below 100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int pool[6] = '{'h10, 'h14, 'h30, 'h21, 'h25, 'h03};
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: cold cache misses everywhere
    cyc("R1", 1, 0, 'h10, 0, 0);
    cyc("R1", 1, 1, 'h03, 0, 0);
    // R2: read miss fill and hit
    cyc("R2", 1, 0, 'h10, 0, 1);
    cyc("R2", 1, 0, 'h10, 0, 0);
    // R3: write miss via read-for-ownership
    cyc("R3", 1, 1, 'h21, 32'hAAAA_0001, 1);
    cyc("R3", 1, 1, 'h21, 32'hAAAA_0001, 0);
    // R4: dirty write stays local
    cyc("R4", 1, 1, 'h21, 32'hBBBB_0002, 0);
    cyc("R4", 1, 0, 'h21, 0, 0);
    // R5: upgrade a shared line
    cyc("R5", 1, 1, 'h10, 32'hCCCC_0003, 1);
    cyc("R5", 1, 1, 'h10, 32'hCCCC_0003, 0);
    // R6: peer read of dirty line, intervention
    cyc("R6", 0, 0, 0, 0, 0, 1, RD, 'h10, 1);
    cyc("R6", 1, 1, 'h10, 32'hDDDD_0004, 0);
    cyc("R6", 1, 0, 'h10, 0, 0);
    // R7: peer ownership request on dirty line
    cyc("R7", 0, 0, 0, 0, 0, 1, RFO, 'h21, 2);
    cyc("R7", 1, 0, 'h21, 0, 0);
    // R8: peer invalidate of a shared line
    cyc("R8", 0, 0, 0, 0, 0, 1, UPG, 'h10, 1);
    cyc("R8", 1, 0, 'h10, 0, 0);
    // R9: dirty victim written back before fill
    cyc("R9", 1, 1, 'h10, 32'hEEEE_0005, 1, 0, 0, 0, 1, 32'h0F0F_0000);
    cyc("R9", 1, 1, 'h10, 32'hEEEE_0005, 0);
    cyc("R9", 1, 0, 'h30, 0, 1);
    cyc("R9", 1, 0, 'h30, 0, 1);
    cyc("R9", 1, 0, 'h30, 0, 0);
    // R10: clean victim dropped silently
    cyc("R10", 1, 0, 'h14, 0, 1);
    cyc("R10", 1, 0, 'h14, 0, 0);
    // R12: own-id transaction ignored
    cyc("R12", 1, 1, 'h14, 32'hFFFF_0006, 1);
    cyc("R12", 1, 1, 'h14, 32'hFFFF_0006, 0);
    cyc("R12", 0, 0, 0, 0, 0, 1, RFO, 'h14, 0);
    cyc("R12", 1, 0, 'h14, 0, 0);
    // R11: snoop owns the cycle
    cyc("R11", 1, 0, 'h25, 0, 1, 1, RD, 'h03, 1);
    cyc("R11", 1, 0, 'h14, 0, 0, 1, RD, 'h10, 1);
    cyc("R11", 1, 0, 'h14, 0, 0);
    // R13: mixed traffic against the reference model
    for (int n = 0; n < 400; n++) begin
      cyc("R13", ($urandom % 4) != 0, $urandom % 2, pool[$urandom % 6], $urandom, $urandom % 2,
          ($urandom % 4) == 0, $urandom % 4, pool[$urandom % 6], $urandom % 3,
          ($urandom % 3 == 0) ? 32'h5A5A_5A5A : 32'h0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule